// File: doc/BRIEF.md
# Single-Wire Bus Byte Sequencer with One-Shot Strong Pullup

This block turns whole-byte requests into eight single-bit slot requests for a bit slot engine below it. A controller picks one of three operations (send a byte, receive a byte, or exchange a byte where each sent bit is also sampled back), pulses `start`, and waits for `done`. Bits go out least significant first. Bit i of the byte is carried by the i-th slot, and the sample from the i-th slot lands in bit i of `rd_byte`. The slot engine gets a one-cycle `slot_start` with the bit value and a flag that says whether the sample matters. It answers with a one-cycle `slot_done` carrying the sampled line level.

Some devices on the bus draw power for a while after they receive a command byte. The controller can book a strong pullup for the next send operation by loading a nonzero duration, counted in `ms_tick` pulses. Loading zero withdraws the booking. The pullup drive comes on as the final slot of the send is issued. After the byte it stays on for the booked number of ticks, and then it is released and the booking is dropped. When the pullup hardware is switched off, the block still waits out the same interval, but it never drives the pullup. Sequences of several bytes are built by an outside controller that issues one operation after another.

Top module: `owire_byte_seq`

## Requirements
- R1: After reset, `busy`, `done`, `spu_en` and `slot_start` are low and `rd_byte` is 0x00.
- R2: With `op_sel` = 2'b00 (send), exactly eight slots are issued. The i-th slot carries `slot_bit` = `wr_byte[i]`, starting with bit 0, and has `slot_rd` low.
- R3: With `op_sel[0]` = 1 (2'b01 or 2'b11, receive), eight slots are issued with `slot_bit` = 1 and `slot_rd` high. The sample of the i-th slot ends up in `rd_byte[i]`.
- R4: With `op_sel` = 2'b10 (exchange), the i-th slot carries `wr_byte[i]` with `slot_rd` high, and its sample replaces bit i in `rd_byte`.
- R5: `busy` rises only in the cycle after an accepted `start`. `done` is a one-cycle pulse in the cycle where `busy` falls. A `start` seen while busy is ignored. Each `slot_start` lasts one cycle and occurs only while busy.
- R6: A `spu_load` pulse while idle books the pullup for `spu_dur` ticks. A zero value cancels the booking. A `spu_load` pulse while busy has no effect.
- R7: On a send with a booking and `spu_hw_en` high, `spu_en` rises in the cycle after the eighth `slot_start`, stays high until the operation ends, and falls in the `done` cycle. It is never high during the earlier slots.
- R8: On a send with a booking of N ticks, `busy` stays high after the eighth `slot_done` until N `ms_tick` pulses have been seen, and `done` follows the N-th pulse by one cycle.
- R9: With `spu_hw_en` low, a booked send waits the same N ticks, but `spu_en` stays low.
- R10: A booking is used by only one send. The next send without a new load ends right after its eighth slot.
- R11: Receive and exchange operations never raise `spu_en`, never wait for ticks, and leave a booking in place for a later send.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_sel | input | 2 | 00 send, 10 exchange, x1 receive |
| wr_byte | input | 8 | Byte to send or exchange |
| start | input | 1 | Begin an operation (accepted when idle) |
| rd_byte | output | 8 | Assembled sampled byte |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| spu_dur | input | DUR_W | Pullup duration in ticks |
| spu_load | input | 1 | Load `spu_dur` as the booking (zero cancels) |
| spu_hw_en | input | 1 | Strong pullup hardware present |
| ms_tick | input | 1 | Millisecond tick pulse |
| spu_en | output | 1 | Strong pullup drive |
| slot_start | output | 1 | Issue one bit slot |
| slot_bit | output | 1 | Bit value for the slot |
| slot_rd | output | 1 | Slot sample is used |
| slot_done | input | 1 | Slot finished |
| slot_sample | input | 1 | Line level sampled in the slot |

## Verification
The case hardest to reach from the ports is a booking that survives or dies through an indirect path: a load pulse landing mid-operation, or a booking that sits through receive and exchange operations before a send uses it. The bench pulses `spu_load` and `start` together in the middle of a send, then checks that the following send adds no wait ticks. It books two ticks, runs a receive and an exchange that must each end with no tick wait and no pullup drive, and then runs a send that must wait exactly two ticks. Wait lengths are measured by counting tick pulses between the eighth `slot_done` and `done`.

// File: rtl/owire_byte_seq.sv
module owire_byte_seq #(
  parameter int DUR_W = 16,
  parameter int NBITS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       op_sel,
  input  logic [NBITS-1:0] wr_byte,
  input  logic             start,
  output logic [NBITS-1:0] rd_byte,
  output logic             busy,
  output logic             done,
  input  logic [DUR_W-1:0] spu_dur,
  input  logic             spu_load,
  input  logic             spu_hw_en,
  input  logic             ms_tick,
  output logic             spu_en,
  output logic             slot_start,
  output logic             slot_bit,
  output logic             slot_rd,
  input  logic             slot_done,
  input  logic             slot_sample
);
  localparam int IDX_W = (NBITS > 1) ? $clog2(NBITS) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NBITS - 1);

  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT, S_HOLD} st_t;

  st_t              st;
  logic [1:0]       op;
  logic [NBITS-1:0] tx;
  logic [NBITS-1:0] rx;
  logic [IDX_W-1:0] idx;
  logic [DUR_W-1:0] pend;
  logic [DUR_W-1:0] cnt;

  wire is_wr  = (op == 2'b00);
  wire is_rd  = op[0];
  wire last   = (idx == LAST_IDX);
  wire booked = (pend != '0);

  assign busy       = (st != S_IDLE);
  assign slot_start = (st == S_ISSUE);
  assign slot_bit   = is_rd ? 1'b1 : tx[idx];
  assign slot_rd    = !is_wr;
  assign rd_byte    = rx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      op     <= 2'b00;
      tx     <= '0;
      rx     <= '0;
      idx    <= '0;
      pend   <= '0;
      cnt    <= '0;
      done   <= 1'b0;
      spu_en <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: begin
          if (spu_load) pend <= spu_dur;
          if (start) begin
            op  <= op_sel;
            tx  <= wr_byte;
            idx <= '0;
            st  <= S_ISSUE;
          end
        end
        S_ISSUE: begin
          if (last && is_wr && booked && spu_hw_en) spu_en <= 1'b1;
          st <= S_WAIT;
        end
        S_WAIT: begin
          if (slot_done) begin
            if (!is_wr) rx[idx] <= slot_sample;
            if (last) begin
              if (is_wr && booked) begin
                cnt <= '0;
                st  <= S_HOLD;
              end else begin
                done <= 1'b1;
                st   <= S_IDLE;
              end
            end else begin
              idx <= idx + 1'b1;
              st  <= S_ISSUE;
            end
          end
        end
        S_HOLD: begin
          if (ms_tick) begin
            if (cnt == pend - 1'b1) begin
              done   <= 1'b1;
              spu_en <= 1'b0;
              pend   <= '0;
              st     <= S_IDLE;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/owire_byte_seq_chk.sv
module owire_byte_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic busy,
  input logic done,
  input logic spu_en,
  input logic slot_start
);
  a_r5_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  a_r5_slot_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    slot_start |=> !slot_start);
  a_r5_slot_busy: assert property (@(posedge clk) disable iff (!rst_n)
    slot_start |-> busy);
  a_r5_busy_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));
  a_r7_spu_busy: assert property (@(posedge clk) disable iff (!rst_n)
    spu_en |-> busy);
  a_r7_spu_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spu_en) |-> $past(slot_start));
  a_r7_spu_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(spu_en) |-> done);
endmodule

bind owire_byte_seq owire_byte_seq_chk u_chk (.*);

// File: tb/tb_owire_byte_seq.sv
module tb_owire_byte_seq;
  localparam int CLK_P    = 10;
  localparam int SLOT_LAT = 3;
  localparam int TICK_P   = 5;

  logic clk = 0, rst_n = 0;
  logic [1:0] op_sel = 0;
  logic [7:0] wr_byte = 0;
  logic start = 0;
  logic [7:0] rd_byte;
  logic busy, done;
  logic [15:0] spu_dur = 0;
  logic spu_load = 0, spu_hw_en = 0, ms_tick = 0;
  logic spu_en, slot_start, slot_bit, slot_rd;
  logic slot_done = 0, slot_sample = 0;

  owire_byte_seq dut (.*);

  always #(CLK_P/2) clk = ~clk;

  int checks = 0, fails = 0, cyc = 0;
  bit to = 0;
  logic [7:0] slave = 0, cap = 0;
  int nslots = 0, lat = 0, ticks = 0, tcnt = 0;
  bit cur = 0, hold = 0, spu_any = 0, spu_all = 1, spu_early = 0, rd_bad = 0;
  bit exp_rd = 0;

  always @(negedge clk) begin
    cyc++;
    if (cyc > 150000) to = 1;
    tcnt = (tcnt == TICK_P - 1) ? 0 : tcnt + 1;
    ms_tick = (tcnt == 0);
    slot_done = 0;
    if (busy && spu_en) spu_any = 1;
    if (hold && busy) begin
      if (ms_tick) ticks++;
      if (!spu_en) spu_all = 0;
    end
    if (slot_start) begin
      if (nslots < 8) cap[nslots] = slot_bit;
      if (slot_rd != exp_rd) rd_bad = 1;
      if (nslots < 7 && spu_en) spu_early = 1;
      cur = slot_bit;
      nslots++;
      lat = SLOT_LAT;
    end else if (lat > 0) begin
      lat--;
      if (lat == 0) begin
        slot_done = 1;
        slot_sample = cur & slave[(nslots - 1) % 8];
        if (nslots == 8) hold = 1;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic book(input int d);
    @(negedge clk);
    spu_dur = 16'(d); spu_load = 1;
    @(negedge clk);
    spu_load = 0;
  endtask

  task automatic run(input logic [1:0] op, input logic [7:0] b, input logic [7:0] s, input bit mid);
    @(negedge clk);
    nslots = 0; cap = 0; hold = 0; ticks = 0; spu_any = 0; spu_all = 1; spu_early = 0; rd_bad = 0;
    slave = s; exp_rd = (op != 2'b00);
    op_sel = op; wr_byte = b; start = 1;
    @(negedge clk);
    start = 0;
    chk(busy, "R5 busy after start", busy, 1);
    if (mid) begin
      @(negedge clk);
      start = 1; op_sel = 2'b01; spu_dur = 3; spu_load = 1;
      @(negedge clk);
      start = 0; spu_load = 0; op_sel = op;
    end
    while (!done && !to) @(negedge clk);
    chk(!busy, "R5 busy low with done", busy, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !done && !spu_en && !slot_start && rd_byte == 0, "R1 reset state",
        {busy, done, spu_en, slot_start}, 0);
    rst_n = 1;

    for (int b = 0; b < 256; b++) begin
      run(2'b00, 8'(b), 8'hFF, 0);
      chk(cap == 8'(b) && nslots == 8 && !rd_bad, "R2 send bits", cap, b);
      chk(ticks == 0 && !spu_any, "R10 no hold without booking", ticks, 0);
    end
    for (int s = 0; s < 256; s++) begin
      run(2'(1 + 2 * (s % 2)), 8'h00, 8'(s), 0);
      chk(rd_byte == 8'(s) && cap == 8'hFF && !rd_bad, "R3 receive", rd_byte, s);
    end
    for (int b = 0; b < 256; b++) begin
      logic [7:0] s;
      s = {8'(b)} ^ 8'h3C;
      s = {s[3:0], s[7:4]};
      run(2'b10, 8'(b), s, 0);
      chk(rd_byte == (8'(b) & s) && cap == 8'(b) && !rd_bad, "R4 exchange", rd_byte, 8'(b) & s);
    end

    run(2'b00, 8'h5A, 8'hFF, 1);
    repeat (10) @(negedge clk);
    chk(!busy && nslots == 8, "R5 start while busy ignored", nslots, 8);
    run(2'b00, 8'h5A, 8'hFF, 0);
    chk(ticks == 0, "R6 load while busy ignored", ticks, 0);

    for (int hw = 0; hw < 2; hw++) begin
      spu_hw_en = 1'(hw);
      for (int d = 1; d <= 4; d++) begin
        book(d);
        run(2'b00, 8'hA5, 8'hFF, 0);
        chk(ticks == d, "R8 hold length", ticks, d);
        chk(!spu_early && !spu_en, "R7 pullup not early and released", spu_en, 0);
        if (hw == 1) chk(spu_any && spu_all, "R7 pullup held through hold", spu_all, 1);
        else chk(!spu_any, "R9 no pullup without hardware", spu_any, 0);
        run(2'b00, 8'hA5, 8'hFF, 0);
        chk(ticks == 0 && !spu_any, "R10 booking used once", ticks, 0);
      end
    end

    spu_hw_en = 1;
    book(5); book(0);
    run(2'b00, 8'h81, 8'hFF, 0);
    chk(ticks == 0 && !spu_any, "R6 zero load cancels", ticks, 0);

    book(2);
    run(2'b01, 8'h00, 8'h96, 0);
    chk(ticks == 0 && !spu_any, "R11 receive no pullup", ticks, 0);
    run(2'b10, 8'hFF, 8'h96, 0);
    chk(ticks == 0 && !spu_any, "R11 exchange no pullup", ticks, 0);
    run(2'b00, 8'h33, 8'hFF, 0);
    chk(ticks == 2 && spu_all, "R11 booking kept for send", ticks, 2);

    if (to) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule